// File: doc/BRIEF.md
# Byte Table Lookup Permuter

This block rearranges bytes. Its table is built from one to four adjacent 64-bit words. Each of the eight bytes of a 64-bit index vector picks one byte out of that table, and the picks together form a new 64-bit word. An index that falls past the end of the table is resolved by one of two policies, chosen by a mode input:

- **Zero-fill:** the output byte becomes zero.
- **Keep:** the output byte takes the matching byte of a supplied destination word.

All eight lanes are resolved in the same cycle. The result is captured in an output register and marked by a valid flag one cycle after the request. Typical uses are shuffles, small substitution tables and gathering bytes from up to 32 bytes of data in a vector datapath.

Top module: `byte_lut_permute`

## Requirements
- R1: While `rst_n` is low, `res_valid` and `res_data` are zero.
- R2: `res_valid` equals the value `req_valid` had at the previous rising clock edge. The result of a request accepted at edge k is present on `res_data` right after edge k.
- R3: Table byte number i is bits [8*(i mod 8)+7 : 8*(i mod 8)] of table word i/8. Table word w sits at bits [64*w+63 : 64*w] of `tbl_words`. Lane j of the output is bits [8j+7:8j] and is selected by bits [8j+7:8j] of `idx_vec`.
- R4: A value n on `tbl_len` (0 to 3) makes the table n+1 words long. An index below 8*(n+1) is in range.
- R5: With `keep_old` = 0, an index equal to or above the table length yields the byte 0x00.
- R6: With `keep_old` = 1, an index equal to or above the table length yields the byte of `dest_old` in the same lane.
- R7: Any index of 32 or more is out of range for every table length, including four words.
- R8: Table words at or past the selected length have no effect on the result.
- R9: In a cycle where `req_valid` is low, `res_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe; inputs are sampled when high |
| tbl_words | input | 256 | Four table words, word 0 in the low bits |
| tbl_len | input | 2 | Table length minus one, in words |
| idx_vec | input | 64 | Eight byte indexes, lane 0 in the low byte |
| dest_old | input | 64 | Destination bytes kept in keep mode |
| keep_old | input | 1 | 1 = keep destination byte, 0 = zero-fill |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_data | output | 64 | Permuted result |

## Verification
Some behaviours are checked by the assertions on every clock, in every lane:

- the valid latency;
- holding of the result when no request arrives;
- the two out-of-range policies, including indexes of 32 and more.

Other behaviours can only be shown by the bench's scenarios:

- the byte numbering across words, and which byte an in-range index fetches;
- that table words past the selected length have no influence;
- the reset values.

The bench covers these with directed vectors and with seeded random vectors, and compares every result against a reference model.

// File: rtl/bytelut_pkg.sv
package bytelut_pkg;

   typedef enum logic {
      OOR_ZERO = 1'b0,
      OOR_KEEP = 1'b1
   } oor_policy_e;

   typedef enum int {
      SEL_INDEXED = 0,
      SEL_ONEHOT  = 1
   } sel_style_e;

   // Number of in-range table bytes for a given length code
   function automatic int unsigned table_limit(input int unsigned len_code,
                                               input int unsigned lanes);
      return (len_code + 1) * lanes;
   endfunction

endpackage

// File: rtl/bytelut_table_view.sv
module bytelut_table_view #(
   parameter int LANES     = 8,
   parameter int BYTE_W    = 8,
   parameter int MAX_WORDS = 4,
   parameter int LEN_W     = 2,
   parameter int IDX_W     = 8
) (
   input  logic [MAX_WORDS*LANES*BYTE_W-1:0] words_i,
   input  logic [LEN_W-1:0]                  len_i,
   output logic [MAX_WORDS*LANES*BYTE_W-1:0] bytes_o,
   output logic [IDX_W-1:0]                  limit_o
);
   import bytelut_pkg::*;

   localparam int WORD_W    = LANES * BYTE_W;
   localparam int TBL_BYTES = MAX_WORDS * LANES;

   // Byte k of word w lands at flat position w*LANES+k (little-endian numbering)
   for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
      for (genvar k = 0; k < LANES; k++) begin : g_byte
         assign bytes_o[(w*LANES+k)*BYTE_W +: BYTE_W] = words_i[w*WORD_W + k*BYTE_W +: BYTE_W];
      end
   end

   always_comb begin
      limit_o = '0;
      for (int n = 0; n < MAX_WORDS; n++) begin
         if (len_i == LEN_W'(n)) limit_o = IDX_W'(table_limit(n, LANES));
      end
   end

   if (TBL_BYTES >= (1 << IDX_W)) begin : g_bad_idx
      $error("table must be smaller than index range");
   end

endmodule

// File: rtl/bytelut_lane.sv
module bytelut_lane #(
   parameter int LANES     = 8,
   parameter int BYTE_W    = 8,
   parameter int MAX_WORDS = 4,
   parameter int IDX_W     = 8,
   parameter int SEL_STYLE = 0
) (
   input  logic [MAX_WORDS*LANES*BYTE_W-1:0] bytes_i,
   input  logic [IDX_W-1:0]                  limit_i,
   input  logic [IDX_W-1:0]                  idx_i,
   input  logic [BYTE_W-1:0]                 old_i,
   input  logic                              keep_i,
   output logic [BYTE_W-1:0]                 res_o
);
   import bytelut_pkg::*;

   localparam int TBL_BYTES = MAX_WORDS * LANES;
   localparam int SEL_W     = $clog2(TBL_BYTES);

   logic [SEL_W-1:0]  sel;
   logic [BYTE_W-1:0] fetched;
   logic              in_range;

   assign sel      = idx_i[SEL_W-1:0];
   assign in_range = (idx_i < limit_i);

   if (SEL_STYLE == SEL_INDEXED) begin : g_indexed
      assign fetched = bytes_i[sel*BYTE_W +: BYTE_W];
   end else if (SEL_STYLE == SEL_ONEHOT) begin : g_onehot
      logic [TBL_BYTES-1:0] hit;
      always_comb begin
         for (int j = 0; j < TBL_BYTES; j++) hit[j] = (sel == SEL_W'(j));
      end
      always_comb begin
         fetched = '0;
         for (int j = 0; j < TBL_BYTES; j++) begin
            fetched = fetched | ({BYTE_W{hit[j]}} & bytes_i[j*BYTE_W +: BYTE_W]);
         end
      end
   end else begin : g_bad_style
      $error("unknown SEL_STYLE");
   end

   always_comb begin
      if (in_range)                   res_o = fetched;
      else if (keep_i == OOR_KEEP)    res_o = old_i;
      else                            res_o = '0;
   end

   if (SEL_W < 1) begin : g_bad_sel
      $error("table needs at least two bytes");
   end

endmodule

// File: rtl/byte_lut_permute.sv
module byte_lut_permute #(
   parameter int LANES     = 8,
   parameter int BYTE_W    = 8,
   parameter int MAX_WORDS = 4,
   parameter int SEL_STYLE = 0
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   input  logic [MAX_WORDS*LANES*BYTE_W-1:0]      tbl_words,
   input  logic [$clog2(MAX_WORDS)-1:0]           tbl_len,
   input  logic [LANES*BYTE_W-1:0]                idx_vec,
   input  logic [LANES*BYTE_W-1:0]                dest_old,
   input  logic                                   keep_old,
   output logic                                   res_valid,
   output logic [LANES*BYTE_W-1:0]                res_data
);
   localparam int WORD_W    = LANES * BYTE_W;
   localparam int TBL_BYTES = MAX_WORDS * LANES;
   localparam int LEN_W     = $clog2(MAX_WORDS);
   localparam int IDX_W     = BYTE_W;

   if (MAX_WORDS < 2)            begin : g_bad_words  $error("MAX_WORDS must be at least 2"); end
   if (LANES < 1)                begin : g_bad_lanes  $error("LANES must be positive");       end
   if ((1 << LEN_W) != MAX_WORDS) begin : g_bad_pow   $error("MAX_WORDS must be a power of two"); end

   logic [TBL_BYTES*BYTE_W-1:0] tbl_bytes;
   logic [IDX_W-1:0]            limit;
   logic [WORD_W-1:0]           next_data;

   bytelut_table_view #(
      .LANES(LANES), .BYTE_W(BYTE_W), .MAX_WORDS(MAX_WORDS),
      .LEN_W(LEN_W), .IDX_W(IDX_W)
   ) view_i (
      .words_i (tbl_words),
      .len_i   (tbl_len),
      .bytes_o (tbl_bytes),
      .limit_o (limit)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      bytelut_lane #(
         .LANES(LANES), .BYTE_W(BYTE_W), .MAX_WORDS(MAX_WORDS),
         .IDX_W(IDX_W), .SEL_STYLE(SEL_STYLE)
      ) lane_i (
         .bytes_i (tbl_bytes),
         .limit_i (limit),
         .idx_i   (idx_vec[l*BYTE_W +: BYTE_W]),
         .old_i   (dest_old[l*BYTE_W +: BYTE_W]),
         .keep_i  (keep_old),
         .res_o   (next_data[l*BYTE_W +: BYTE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) res_data <= next_data;
      end
   end

   // Result strobe trails the request strobe by one cycle (R2)
   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid == 1'b1 |=> res_valid == 1'b1);
   assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid == 1'b0 |=> res_valid == 1'b0);

   // No request, no change (R9)
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(res_data));

   for (genvar l = 0; l < LANES; l++) begin : g_chk
      // Zero-fill policy (R5)
      assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !keep_old && idx_vec[l*BYTE_W +: BYTE_W] >= limit)
         |=> res_data[l*BYTE_W +: BYTE_W] == '0);
      // Keep policy (R6)
      assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && keep_old && idx_vec[l*BYTE_W +: BYTE_W] >= limit)
         |=> res_data[l*BYTE_W +: BYTE_W] == $past(dest_old[l*BYTE_W +: BYTE_W]));
      // Indexes past the largest table never fetch (R7)
      assert_far_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && idx_vec[l*BYTE_W +: BYTE_W] >= IDX_W'(TBL_BYTES))
         |=> res_data[l*BYTE_W +: BYTE_W] ==
             ($past(keep_old) ? $past(dest_old[l*BYTE_W +: BYTE_W]) : '0));
   end

endmodule

// File: tb/byte_lut_permute_tb.sv
module byte_lut_permute_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [255:0] tbl_words = '0;
   logic [1:0]   tbl_len = '0;
   logic [63:0]  idx_vec = '0;
   logic [63:0]  dest_old = '0;
   logic         keep_old = 1'b0;
   logic         res_valid;
   logic [63:0]  res_data;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   byte_lut_permute dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .tbl_words(tbl_words), .tbl_len(tbl_len), .idx_vec(idx_vec),
      .dest_old(dest_old), .keep_old(keep_old),
      .res_valid(res_valid), .res_data(res_data)
   );

   function automatic logic [63:0] ref_perm(input logic [255:0] t, input logic [1:0] len,
                                            input logic [63:0] ix, input logic [63:0] old,
                                            input logic keep);
      logic [63:0] r;
      for (int l = 0; l < 8; l++) begin
         int i = int'(ix[8*l +: 8]);
         int lim = 8 * (int'(len) + 1);
         if (i < lim)   r[8*l +: 8] = t[8*i +: 8];
         else if (keep) r[8*l +: 8] = old[8*l +: 8];
         else           r[8*l +: 8] = 8'h00;
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One request: drive at falling edge, sample 1 ns after the capturing edge
   task automatic run(input logic [255:0] t, input logic [1:0] len, input logic [63:0] ix,
                      input logic [63:0] old, input logic keep, input string req);
      logic [63:0] exp;
      @(negedge clk);
      req_valid = 1'b1; tbl_words = t; tbl_len = len; idx_vec = ix; dest_old = old; keep_old = keep;
      exp = ref_perm(t, len, ix, old, keep);
      @(posedge clk); #1;
      chk(res_valid === 1'b1, "R2", {63'd0, res_valid}, 64'd1);
      chk(res_data === exp, req, res_data, exp);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [255:0] rnd_table();
      logic [255:0] t;
      for (int k = 0; k < 8; k++) t[32*k +: 32] = $urandom;
      return t;
   endfunction

   function automatic logic [63:0] rnd_idx();
      logic [63:0] v;
      for (int l = 0; l < 8; l++) begin
         if (($urandom % 8) == 0) v[8*l +: 8] = 8'($urandom);
         else                     v[8*l +: 8] = 8'($urandom % 40);
      end
      return v;
   endfunction

   initial begin : watchdog
      #(4 * 150000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      logic [255:0] seq_tbl;
      logic [255:0] t2;
      logic [63:0]  held;
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      for (int b = 0; b < 32; b++) seq_tbl[8*b +: 8] = 8'(8'hA0 + b);

      // R1: reset state
      #5;
      chk(res_valid === 1'b0, "R1", {63'd0, res_valid}, 64'd0);
      chk(res_data === 64'd0, "R1", res_data, 64'd0);
      @(negedge clk); rst_n = 1'b1;

      // R3: byte numbering within the first word and across the last word
      run(seq_tbl, 2'd3, 64'h0706050403020100, 64'd0, 1'b0, "R3");
      chk(res_data === 64'hA7A6A5A4A3A2A1A0, "R3", res_data, 64'hA7A6A5A4A3A2A1A0);
      run(seq_tbl, 2'd3, 64'h1F18100800090A1E, 64'd0, 1'b0, "R3");
      chk(res_data === 64'hBFB8B0A8A0A9AABE, "R3", res_data, 64'hBFB8B0A8A0A9AABE);

      // R4, R5: one-word table, index 8 and above zero-filled
      run(seq_tbl, 2'd0, 64'h0708091011070000, 64'h1122334455667788, 1'b0, "R5");
      chk(res_data === 64'hA7000000_00A7A0A0, "R4", res_data, 64'hA700000000A7A0A0);
      // R6: same vector, keep mode
      run(seq_tbl, 2'd0, 64'h0708091011070000, 64'h1122334455667788, 1'b1, "R6");
      chk(res_data === 64'hA7223344_55A7A0A0, "R6", res_data, 64'hA722334455A7A0A0);
      // R4: three-word table, index 23 in, 24 out
      run(seq_tbl, 2'd2, 64'h0000000000001718, 64'hFFFFFFFFFFFFFFFF, 1'b1, "R4");
      chk(res_data[15:0] === 16'hB7FF, "R4", {48'd0, res_data[15:0]}, 64'hB7FF);

      // R7: indexes 32, 0x80, 0xFF with four words
      run(seq_tbl, 2'd3, 64'h2021407F80C0FEFF, 64'h0123456789ABCDEF, 1'b0, "R7");
      run(seq_tbl, 2'd3, 64'h2021407F80C0FEFF, 64'h0123456789ABCDEF, 1'b1, "R7");
      chk(res_data === 64'h0123456789ABCDEF, "R7", res_data, 64'h0123456789ABCDEF);

      // R8: words past the selected length are changed; result must not move
      run(seq_tbl, 2'd1, 64'h0F0E1A1B1C0E0D0C, 64'h5A5A5A5A5A5A5A5A, 1'b1, "R8");
      held = res_data;
      t2 = seq_tbl;
      t2[255:128] = ~t2[255:128];
      run(t2, 2'd1, 64'h0F0E1A1B1C0E0D0C, 64'h5A5A5A5A5A5A5A5A, 1'b1, "R8");
      chk(res_data === held, "R8", res_data, held);

      // R9 and R2: idle cycles with changing inputs
      held = res_data;
      @(negedge clk);
      req_valid = 1'b0; idx_vec = 64'h0001020304050607; tbl_len = 2'd3; keep_old = 1'b0;
      @(posedge clk); #1;
      chk(res_valid === 1'b0, "R2", {63'd0, res_valid}, 64'd0);
      chk(res_data === held, "R9", res_data, held);
      @(posedge clk); #1;
      chk(res_data === held, "R9", res_data, held);

      // Random mix over all lengths and both policies (R3 R4 R5 R6)
      for (int n = 0; n < 600; n++) begin
         run(rnd_table(), 2'($urandom), rnd_idx(), {$urandom, $urandom}, 1'($urandom), "R3_R4_R5_R6");
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule